// File: doc/BRIEF.md
# Ultra DMA Write Data Receiver

This block sits on the device side of a parallel ATA link. It receives the data-out direction of an Ultra DMA burst, the kind a write DMA command uses. The host owns a strobe line and changes it once per data word. A fast system clock oversamples this strobe through a synchroniser, and both the rising and the falling transition each capture one 16-bit word from the host data bus. Captured words go into a small FIFO, which hands them on over a valid/ready interface.

The on-chip command logic starts a burst with a one-cycle request. The request is accepted only while the host write strobe line is low. After that the receiver waits until the host STOP line is low, and only then treats strobe transitions as data. The host pauses the flow by leaving the strobe at one level, and the receiver waits in the burst without capturing anything. When the host raises STOP, the burst ends: the receiver returns to idle and raises a terminated flag. A 16-bit counter holds the number of words the most recent burst delivered.

Top module: `udma_wr_rx`

## Requirements
- R1: After an active-low synchronous reset, the following are all zero: `burst_active`, `burst_stopped`, `overflow_err`, `word_count` and `out_valid`.
- R2: A `burst_req` pulse that arrives while the synchronised `host_wr` is high is ignored, and `burst_active` stays 0.
- R3: After a burst is accepted, `burst_active` is 1. While `host_stop` is high, strobe transitions capture nothing: `out_valid` and `word_count` stay 0.
- R4: Once a burst is running and STOP is low, each rising transition and each falling transition of `host_strobe` captures `host_data` as one word. The words leave the FIFO in the order they were captured.
- R5: While `host_strobe` stays at one level during a running burst, `burst_active` remains 1 and no word is captured.
- R6: Raising `host_stop` during a running burst returns the block to idle, with `burst_active` 0 and `burst_stopped` 1. Strobe transitions after that capture nothing.
- R7: `word_count` counts the words captured in the current or most recent burst. It goes to 0 and `burst_stopped` goes to 0 on the cycle a burst is accepted, and the count holds its value after the burst ends.
- R8: The FIFO holds 8 words. A word captured while the FIFO is full and no word is being taken is dropped, and `overflow_err` is set. `overflow_err` stays set until reset, and the 8 stored words are kept unchanged.
- R9: A word leaves the FIFO on a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady.
- R10: While no burst is active, strobe transitions capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the strobe toggle rate |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_req | input | 1 | One-cycle request from the command logic to start a burst |
| host_wr | input | 1 | Host write strobe line, asserted high; must be low for a start |
| host_stop | input | 1 | Host STOP line, high ends the burst |
| host_strobe | input | 1 | Host data strobe; each transition marks one word |
| host_data | input | 16 | Host data bus |
| out_data | output | 16 | Oldest word in the FIFO |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Consumer takes the word on this cycle |
| burst_active | output | 1 | A burst is accepted and not yet ended |
| burst_stopped | output | 1 | The last burst was ended by STOP |
| word_count | output | 16 | Words captured in the current or last burst |
| overflow_err | output | 1 | Sticky: a word was dropped because the FIFO was full |

## Verification
If the edge detector holds a wrong reference level, it shows within about three clock cycles of a strobe change. It appears as a missing word, or as an extra word that the counter and `out_valid` both reveal. A state machine stuck in the wrong state shows up as `burst_active` or `burst_stopped` disagreeing with the STOP and request history a few cycles after the lines settle. FIFO pointer faults appear when the words are drained, as data out of order or as words lost beyond the eighth.

// File: rtl/udma_rx_pkg.sv
// Package: shared types for the Ultra DMA write data receiver.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package udma_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ARM  = 2'd1,
        RX_XFER = 2'd2
    } rx_state_t;
endpackage

// File: rtl/udma_rx_sync.sv
// Module: multi-stage flop synchroniser for a bundle of asynchronous lines.
// Assumes each line is slow compared with clk, so bits may be treated
// independently; resets every stage to zero.
module udma_rx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    // Remaining stages shift the sample onward.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/udma_rx_fifo.sv
// Module: small synchronous FIFO with a sticky overflow flag.
// Assumes one writer pulse per word; a push into a full FIFO without a
// simultaneous pop drops the word and sets ovf until reset.
module udma_rx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic         ovf
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVW = $clog2(DEPTH + 1);

    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [LVW-1:0] level;
    logic           pop, accept;

    assign pop      = rd_valid && rd_ready;
    assign accept   = push && ((level < LVW'(DEPTH)) || pop);
    assign rd_valid = (level != '0);
    assign rd_data  = mem[rd_ptr];

    // Storage write for accepted words.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // Pointer, fill level and sticky overflow maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (accept && !pop)      level <= level + 1'b1;
            else if (!accept && pop) level <= level - 1'b1;
            if (push && !accept)     ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/udma_rx_ctrl.sv
// Module: burst state machine, double-edge strobe detector and word counter.
// Assumes strobe, STOP and write lines arrive already synchronised and the
// data word is registered one cycle after the strobe sample.
module udma_rx_ctrl
    import udma_rx_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          wr_s,
    input  logic          stop_s,
    input  logic          strb_s,
    input  logic [W-1:0]  data_q,
    output logic          push,
    output logic [W-1:0]  push_data,
    output logic          active,
    output logic          stopped,
    output logic [CW-1:0] count
);
    rx_state_t state, state_nx;
    logic      strb_prev;
    logic      start_ok;

    assign start_ok  = (state == RX_IDLE) && start_req && !wr_s;
    assign push      = (state == RX_XFER) && !stop_s && (strb_s != strb_prev);
    assign push_data = data_q;
    assign active    = (state != RX_IDLE);

    // Next-state choice for the burst sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: if (start_ok) state_nx = RX_ARM;
            RX_ARM:  if (!stop_s)  state_nx = RX_XFER;
            RX_XFER: if (stop_s)   state_nx = RX_IDLE;
            default:               state_nx = RX_IDLE;
        endcase
    end

    // State register and strobe reference level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            strb_prev <= 1'b0;
        end else begin
            state     <= state_nx;
            strb_prev <= strb_s;
        end
    end

    // Terminated flag and per-burst word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped <= 1'b0;
            count   <= '0;
        end else if (start_ok) begin
            stopped <= 1'b0;
            count   <= '0;
        end else begin
            if ((state == RX_XFER) && stop_s) stopped <= 1'b1;
            if (push) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/udma_wr_rx.sv
// Module: top of the Ultra DMA write data receiver.
// Assumes clk runs at least 4x the host strobe toggle rate and the host
// holds data stable around each strobe transition.
module udma_wr_rx #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req,
    input  logic              host_wr,
    input  logic              host_stop,
    input  logic              host_strobe,
    input  logic [DATA_W-1:0] host_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              burst_active,
    output logic              burst_stopped,
    output logic [CNT_W-1:0]  word_count,
    output logic              overflow_err
);
    logic [2:0]        sync_q;
    logic              wr_sync, stop_sync, strb_sync;
    logic [DATA_W-1:0] data_q;
    logic              cap_push;
    logic [DATA_W-1:0] cap_data;

    udma_rx_sync #(.W(3), .STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({host_wr, host_stop, host_strobe}), .q(sync_q)
    );
    assign {wr_sync, stop_sync, strb_sync} = sync_q;

    // Data bus register, one cycle behind the strobe's first sample.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= host_data;
    end

    udma_rx_ctrl #(.W(DATA_W), .CW(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_req(burst_req),
        .wr_s(wr_sync), .stop_s(stop_sync), .strb_s(strb_sync),
        .data_q(data_q), .push(cap_push), .push_data(cap_data),
        .active(burst_active), .stopped(burst_stopped), .count(word_count)
    );

    udma_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(cap_push), .push_data(cap_data),
        .rd_data(out_data), .rd_valid(out_valid), .rd_ready(out_ready),
        .ovf(overflow_err)
    );
endmodule

// File: rtl/udma_wr_rx_chk.sv
// Module: property checker for udma_wr_rx, attached by bind.
// Assumes it observes the top's ports plus the synchronised write line
// and the capture pulse.
module udma_wr_rx_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_active,
    input logic              burst_stopped,
    input logic              overflow_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [CNT_W-1:0]  word_count,
    input logic              wr_sync,
    input logic              cap_push
);
    assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && wr_sync) |=> !burst_active);

    assert_stop_flags_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_active) |-> burst_stopped);

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> (word_count == '0) && !burst_stopped);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |=> (word_count == $past(word_count) + 1'b1));

    assert_no_idle_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> burst_active);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));
endmodule

bind udma_wr_rx udma_wr_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .burst_active(burst_active),
    .burst_stopped(burst_stopped), .overflow_err(overflow_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .word_count(word_count), .wr_sync(wr_sync), .cap_push(cap_push)
);

// File: tb/udma_wr_rx_tb_top.sv
// Directed bench for udma_wr_rx: one task per scenario, 125 MHz clock.
module udma_wr_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_stop = 1'b0;
    logic        host_strobe = 1'b0;
    logic [15:0] host_data = '0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        burst_active, burst_stopped, overflow_err;
    logic [15:0] word_count;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    udma_wr_rx dut_i (
        .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .host_wr(host_wr),
        .host_stop(host_stop), .host_strobe(host_strobe), .host_data(host_data),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .burst_active(burst_active), .burst_stopped(burst_stopped),
        .word_count(word_count), .overflow_err(overflow_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic send_word(input logic [15:0] w);
        host_data = w;
        cycles(2);
        host_strobe = ~host_strobe;
        cycles(4);
    endtask

    task automatic request_burst();
        burst_req = 1'b1;
        cycles(1);
        burst_req = 1'b0;
        cycles(3);
    endtask

    task automatic raise_stop();
        host_stop = 1'b1;
        cycles(5);
    endtask

    task automatic pop_check(input string req, input logic [15:0] exp);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " data"}, 32'(out_data), 32'(exp));
        out_ready = 1'b1;
        cycles(1);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 active", 32'(burst_active), 0);
        chk("R1 stopped", 32'(burst_stopped), 0);
        chk("R1 overflow", 32'(overflow_err), 0);
        chk("R1 count", 32'(word_count), 0);
        chk("R1 valid", 32'(out_valid), 0);
    endtask

    task automatic t_wr_blocks_start();
        host_wr = 1'b1;
        cycles(4);
        request_burst();
        cycles(2);
        chk("R2 active", 32'(burst_active), 0);
        host_wr = 1'b0;
        cycles(4);
    endtask

    task automatic t_idle_strobe();
        send_word(16'h1111);
        send_word(16'h2222);
        chk("R10 valid", 32'(out_valid), 0);
        chk("R10 count", 32'(word_count), 0);
    endtask

    task automatic t_main_burst();
        host_stop = 1'b1;
        cycles(4);
        request_burst();
        chk("R3 active", 32'(burst_active), 1);
        send_word(16'hdead);
        send_word(16'hbeef);
        chk("R3 valid", 32'(out_valid), 0);
        chk("R3 count", 32'(word_count), 0);
        host_stop = 1'b0;
        cycles(5);
        send_word(16'hA001);
        send_word(16'hA002);
        send_word(16'hA003);
        send_word(16'hA004);
        chk("R4 count both edges", 32'(word_count), 4);
        cycles(20);
        chk("R5 active in pause", 32'(burst_active), 1);
        chk("R5 count in pause", 32'(word_count), 4);
        chk("R9 head held", 32'(out_data), 32'h0000A001);
        pop_check("R4 order 1", 16'hA001);
        pop_check("R4 order 2", 16'hA002);
        pop_check("R4 order 3", 16'hA003);
        pop_check("R4 order 4", 16'hA004);
        chk("R9 drained", 32'(out_valid), 0);
        raise_stop();
        chk("R6 active", 32'(burst_active), 0);
        chk("R6 stopped", 32'(burst_stopped), 1);
        send_word(16'h5555);
        chk("R6 no capture", 32'(out_valid), 0);
        chk("R7 count holds", 32'(word_count), 4);
        host_stop = 1'b0;
        cycles(4);
    endtask

    task automatic t_second_burst();
        request_burst();
        chk("R7 count cleared", 32'(word_count), 0);
        chk("R7 stopped cleared", 32'(burst_stopped), 0);
        send_word(16'h0B01);
        send_word(16'h0B02);
        chk("R7 count", 32'(word_count), 2);
        raise_stop();
        pop_check("R7 drain 1", 16'h0B01);
        pop_check("R7 drain 2", 16'h0B02);
        host_stop = 1'b0;
        cycles(4);
    endtask

    task automatic t_overflow();
        request_burst();
        for (int i = 0; i < 9; i++) send_word(16'hC000 + 16'(i));
        chk("R8 count", 32'(word_count), 9);
        chk("R8 overflow", 32'(overflow_err), 1);
        for (int i = 0; i < 8; i++) pop_check("R8 kept", 16'hC000 + 16'(i));
        chk("R8 ninth dropped", 32'(out_valid), 0);
        raise_stop();
        chk("R8 sticky", 32'(overflow_err), 1);
        host_stop = 1'b0;
        do_reset();
        chk("R1 overflow cleared", 32'(overflow_err), 0);
    endtask

    initial begin
        t_reset();
        t_wr_blocks_start();
        t_idle_strobe();
        t_main_burst();
        t_second_burst();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule